// File: doc/BRIEF.md
# Coincidence-Window Event Selection Trigger

This block decides whether a detector event should be kept. It sits after the per-pixel discriminators of a 16-pixel detector and receives one hit per clock cycle: a pixel index and a 12-bit amplitude. While idle it waits. The first valid hit opens a coincidence window of programmable length, and every hit inside that window is folded into a hit mask and a per-pixel peak amplitude.

When the window closes, the block spends one cycle on evaluation and applies its qualification stages in a fixed priority order:

1. The active-pixel count must lie strictly between a lower and an upper bound.
2. The number of clusters must not exceed a limit. A cluster is a maximal run of adjacent pixel indices.
3. At least one cluster must have a peak amplitude below an amplitude ceiling.

A kept event produces a one-cycle accept strobe for a downstream packet builder. This strobe carries the hit mask, the pixel count and the cluster count. A dropped event produces a one-cycle reject strobe with a reason code. In both cases the block returns to idle.

The thresholds are static inputs. They are expected to stay stable while a window is open and during evaluation.

Top module: `coinc_trigger`

## Requirements
- R1: In idle, the first cycle with `hitValid` high opens a window and that hit is recorded. Hits are collected in the opening cycle and in the following `winLen-1` cycles, so the window spans `winLen` cycles in total. A `winLen` of 0 behaves as 1.
- R2: A pixel hit more than once within a window keeps the larger of its amplitudes.
- R3: Hits presented after the window has closed are ignored. This covers the cycle in which the window closes and the evaluation cycle. A new window can open in the first idle cycle, which is the cycle in which the outcome strobe is high.
- R4: The outcome strobe (`acceptValid` or `rejectValid`) is high for exactly one cycle. That cycle starts at the (`winLen`+1)-th rising edge after the opening edge, where a `winLen` of 0 counts as 1. No strobe is raised earlier during the event.
- R5: With active-pixel count P, the event passes the count stage only when `pixMin` < P < `pixMax`. Otherwise it is rejected with `rejectReason` = 0. This stage has the highest priority.
- R6: Clusters are maximal runs of consecutive active pixel indices. A cluster count greater than `clusLimit` rejects the event with `rejectReason` = 1. A count equal to `clusLimit` passes.
- R7: A cluster's amplitude is the largest amplitude among its pixels. If no cluster has an amplitude strictly below `ampMax`, the event is rejected with `rejectReason` = 2. A cluster whose amplitude equals `ampMax` counts as vetoed.
- R8: An event passing all stages raises `acceptValid`. In the same cycle, `acceptMask` shows the hit mask with bit i for pixel i, `acceptPixCnt` shows P and `acceptClusCnt` shows the cluster count.
- R9: Every event yields exactly one of the two strobes, and the two strobes are never high together.
- R10: After reset, both strobes are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hitValid | input | 1 | A discriminator hit is present this cycle |
| hitPixel | input | 4 | Index of the hit pixel |
| hitAmp | input | 12 | Amplitude of the hit |
| winLen | input | 16 | Coincidence window length in cycles |
| pixMin | input | 5 | Exclusive lower bound on active pixel count |
| pixMax | input | 5 | Exclusive upper bound on active pixel count |
| clusLimit | input | 5 | Largest allowed cluster count |
| ampMax | input | 12 | Cluster amplitude ceiling |
| acceptValid | output | 1 | One-cycle accept strobe |
| acceptMask | output | 16 | Hit mask of the accepted event |
| acceptPixCnt | output | 5 | Active pixel count of the accepted event |
| acceptClusCnt | output | 5 | Cluster count of the accepted event |
| rejectValid | output | 1 | One-cycle reject strobe |
| rejectReason | output | 2 | 0 pixel count, 1 cluster count, 2 amplitude |

## Verification
Random events use window lengths from 0 to 8 and sparse or dense hit trains. They include extra hits in the two cycles after the window. This separates a window that is one cycle too short or too long from a correct one, and shows whether stale hits leak into the mask.

Directed events put the pixel count exactly on each bound, the cluster count on and just past its limit, and a peak amplitude equal to the ceiling. These cases tell strict comparisons from inclusive ones and check that the reject stages keep their priority.

A repeated pixel with a rising and then a falling amplitude separates keeping the larger amplitude from keeping the latest one. A back-to-back event opened in the strobe cycle checks that re-arming takes no extra cycle.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic openWin;   // first hit of a new window: reload the mask
    logic takeHit;   // hit inside an open window: merge it
    logic evalNow;   // window closed: register the outcome
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    REJ_PIXCNT  = 2'd0,
    REJ_CLUSCNT = 2'd1,
    REJ_AMP     = 2'd2
  } rejCode_t;

endpackage

// File: rtl/coinc_ctrl.sv
module coinc_ctrl
  import coinc_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hitValid,
  input  logic [WIN_W-1:0] winLen,
  output ctrlStrobes_t     strobes
);

  typedef enum logic [1:0] {ST_IDLE, ST_OPEN, ST_EVAL} state_t;

  state_t           state;
  logic [WIN_W-1:0] winCnt;
  logic [WIN_W-1:0] effWin;

  assign effWin = (winLen == '0) ? WIN_W'(1) : winLen;

  always_comb begin
    strobes.openWin = (state == ST_IDLE) && hitValid;
    strobes.takeHit = (state == ST_OPEN) && hitValid && (winCnt < effWin);
    strobes.evalNow = (state == ST_EVAL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      winCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (hitValid) begin
            state  <= ST_OPEN;
            winCnt <= WIN_W'(1);
          end
        end
        ST_OPEN: begin
          if (winCnt >= effWin) state <= ST_EVAL;
          else                  winCnt <= winCnt + WIN_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  eval_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL) |=> (state == ST_IDLE));

  // R1
  win_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_OPEN) && $stable(winLen)) |-> (winCnt <= effWin));

  // R3
  no_hit_in_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL) |-> !(strobes.takeHit || strobes.openWin));

endmodule

// File: rtl/coinc_cluster_eval.sv
module coinc_cluster_eval #(
  parameter int NUM_PIX = 16,
  parameter int AMP_W   = 12,
  parameter int CNT_W   = $clog2(NUM_PIX + 1)
) (
  input  logic [NUM_PIX-1:0]       mask,
  input  logic [NUM_PIX*AMP_W-1:0] ampFlat,
  input  logic [AMP_W-1:0]         ampMax,
  output logic [CNT_W-1:0]         pixCnt,
  output logic [CNT_W-1:0]         clusCnt,
  output logic                     anyClusOk
);

  logic [NUM_PIX-1:0] lowAmp;
  logic [NUM_PIX-1:0] runStart;
  logic [NUM_PIX:0]   maskExt;

  assign maskExt  = {1'b0, mask};
  assign runStart = mask & ~{mask[NUM_PIX-2:0], 1'b0};

  for (genvar i = 0; i < NUM_PIX; i++) begin : g_low
    assign lowAmp[i] = ampFlat[i*AMP_W +: AMP_W] < ampMax;
  end

  always_comb begin
    pixCnt  = '0;
    clusCnt = '0;
    for (int i = 0; i < NUM_PIX; i++) begin
      pixCnt  = pixCnt + CNT_W'(mask[i]);
      clusCnt = clusCnt + CNT_W'(runStart[i]);
    end
  end

  // A cluster is good when every member lies below the ceiling,
  // i.e. its peak amplitude is below the ceiling.
  always_comb begin
    logic runGood;
    runGood   = 1'b1;
    anyClusOk = 1'b0;
    for (int i = 0; i < NUM_PIX; i++) begin
      if (mask[i]) begin
        runGood = runGood & lowAmp[i];
        if (!maskExt[i+1]) begin
          anyClusOk = anyClusOk | runGood;
          runGood   = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/coinc_datapath.sv
module coinc_datapath
  import coinc_pkg::*;
#(
  parameter int NUM_PIX = 16,
  parameter int AMP_W   = 12,
  parameter int IDX_W   = $clog2(NUM_PIX),
  parameter int CNT_W   = $clog2(NUM_PIX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [IDX_W-1:0]   hitPixel,
  input  logic [AMP_W-1:0]   hitAmp,
  input  logic [CNT_W-1:0]   pixMin,
  input  logic [CNT_W-1:0]   pixMax,
  input  logic [CNT_W-1:0]   clusLimit,
  input  logic [AMP_W-1:0]   ampMax,
  output logic               acceptValid,
  output logic [NUM_PIX-1:0] acceptMask,
  output logic [CNT_W-1:0]   acceptPixCnt,
  output logic [CNT_W-1:0]   acceptClusCnt,
  output logic               rejectValid,
  output logic [1:0]         rejectReason
);

  logic [NUM_PIX-1:0]       hitMask;
  logic [AMP_W-1:0]         ampReg [NUM_PIX];
  logic [NUM_PIX*AMP_W-1:0] ampFlat;
  logic [CNT_W-1:0]         pixCnt;
  logic [CNT_W-1:0]         clusCnt;
  logic                     anyClusOk;

  for (genvar i = 0; i < NUM_PIX; i++) begin : g_pix
    logic sel;
    assign sel = (int'(hitPixel) == i);
    assign ampFlat[i*AMP_W +: AMP_W] = ampReg[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hitMask[i] <= 1'b0;
        ampReg[i]  <= '0;
      end else if (strobes.openWin) begin
        hitMask[i] <= sel;
        ampReg[i]  <= sel ? hitAmp : '0;
      end else if (strobes.takeHit && sel) begin
        hitMask[i] <= 1'b1;
        if (!hitMask[i] || hitAmp > ampReg[i]) ampReg[i] <= hitAmp;
      end
    end
  end

  coinc_cluster_eval #(
    .NUM_PIX(NUM_PIX), .AMP_W(AMP_W), .CNT_W(CNT_W)
  ) eval_i (
    .mask      (hitMask),
    .ampFlat   (ampFlat),
    .ampMax    (ampMax),
    .pixCnt    (pixCnt),
    .clusCnt   (clusCnt),
    .anyClusOk (anyClusOk)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptValid   <= 1'b0;
      acceptMask    <= '0;
      acceptPixCnt  <= '0;
      acceptClusCnt <= '0;
      rejectValid   <= 1'b0;
      rejectReason  <= '0;
    end else begin
      acceptValid <= 1'b0;
      rejectValid <= 1'b0;
      if (strobes.evalNow) begin
        if (!((pixCnt > pixMin) && (pixCnt < pixMax))) begin
          rejectValid  <= 1'b1;
          rejectReason <= REJ_PIXCNT;
        end else if (clusCnt > clusLimit) begin
          rejectValid  <= 1'b1;
          rejectReason <= REJ_CLUSCNT;
        end else if (!anyClusOk) begin
          rejectValid  <= 1'b1;
          rejectReason <= REJ_AMP;
        end else begin
          acceptValid   <= 1'b1;
          acceptMask    <= hitMask;
          acceptPixCnt  <= pixCnt;
          acceptClusCnt <= clusCnt;
        end
      end
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptValid && rejectValid));

  // R4
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptValid |=> !acceptValid);

  // R4
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectValid |=> !rejectValid);

  // R7
  reason_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectValid |-> (rejectReason != 2'd3));

  // R8
  accept_counts_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptValid |-> ((acceptClusCnt != '0) && (acceptClusCnt <= acceptPixCnt)
                     && (acceptPixCnt == CNT_W'($countones(acceptMask)))));

  // R3
  mask_hold_in_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evalNow |=> $stable(hitMask));

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_pkg::*;
#(
  parameter int NUM_PIX = 16,
  parameter int AMP_W   = 12,
  parameter int WIN_W   = 16,
  localparam int IDX_W  = $clog2(NUM_PIX),
  localparam int CNT_W  = $clog2(NUM_PIX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hitValid,
  input  logic [IDX_W-1:0]   hitPixel,
  input  logic [AMP_W-1:0]   hitAmp,
  input  logic [WIN_W-1:0]   winLen,
  input  logic [CNT_W-1:0]   pixMin,
  input  logic [CNT_W-1:0]   pixMax,
  input  logic [CNT_W-1:0]   clusLimit,
  input  logic [AMP_W-1:0]   ampMax,
  output logic               acceptValid,
  output logic [NUM_PIX-1:0] acceptMask,
  output logic [CNT_W-1:0]   acceptPixCnt,
  output logic [CNT_W-1:0]   acceptClusCnt,
  output logic               rejectValid,
  output logic [1:0]         rejectReason
);

  ctrlStrobes_t strobes;

  coinc_ctrl #(.WIN_W(WIN_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .hitValid (hitValid),
    .winLen   (winLen),
    .strobes  (strobes)
  );

  coinc_datapath #(
    .NUM_PIX(NUM_PIX), .AMP_W(AMP_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .hitPixel      (hitPixel),
    .hitAmp        (hitAmp),
    .pixMin        (pixMin),
    .pixMax        (pixMax),
    .clusLimit     (clusLimit),
    .ampMax        (ampMax),
    .acceptValid   (acceptValid),
    .acceptMask    (acceptMask),
    .acceptPixCnt  (acceptPixCnt),
    .acceptClusCnt (acceptClusCnt),
    .rejectValid   (rejectValid),
    .rejectReason  (rejectReason)
  );

endmodule

// File: tb/coinc_trigger_tb_top.sv
module coinc_trigger_tb_top;

  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hitValid = 1'b0;
  logic [3:0]  hitPixel = '0;
  logic [11:0] hitAmp = '0;
  logic [15:0] winLen = 16'd1;
  logic [4:0]  pixMin = 5'd0;
  logic [4:0]  pixMax = 5'd16;
  logic [4:0]  clusLimit = 5'd8;
  logic [11:0] ampMax = 12'hFFF;
  logic        acceptValid;
  logic [15:0] acceptMask;
  logic [4:0]  acceptPixCnt;
  logic [4:0]  acceptClusCnt;
  logic        rejectValid;
  logic [1:0]  rejectReason;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Per-offset stimulus of one event (offset 0 opens the window)
  bit evV [0:15];
  int evP [0:15];
  int evA [0:15];

  always #5 clk = ~clk;

  coinc_trigger dut_i (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitPixel(hitPixel),
    .hitAmp(hitAmp), .winLen(winLen), .pixMin(pixMin), .pixMax(pixMax),
    .clusLimit(clusLimit), .ampMax(ampMax), .acceptValid(acceptValid),
    .acceptMask(acceptMask), .acceptPixCnt(acceptPixCnt),
    .acceptClusCnt(acceptClusCnt), .rejectValid(rejectValid),
    .rejectReason(rejectReason)
  );

  task automatic check(input bit ok, input string req, input string msg,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  task automatic clearEvent();
    for (int i = 0; i < 16; i++) begin
      evV[i] = 0; evP[i] = 0; evA[i] = 0;
    end
  endtask

  // Expected outcome from the requirements
  task automatic predict(input int wl, output bit acc, output int reason,
                         output bit [15:0] mask, output int pc, output int cc);
    int eff;
    int amp [NP];
    int peak;
    bit anyOk;
    eff = (wl == 0) ? 1 : wl;
    mask = '0;
    for (int i = 0; i < NP; i++) amp[i] = 0;
    for (int o = 0; o < eff; o++) begin
      if (evV[o]) begin
        if (!mask[evP[o]] || evA[o] > amp[evP[o]]) amp[evP[o]] = evA[o];
        mask[evP[o]] = 1'b1;
      end
    end
    pc = 0; cc = 0; anyOk = 0; peak = 0;
    for (int i = 0; i < NP; i++) begin
      if (mask[i]) begin
        pc++;
        if (i == 0 || !mask[i-1]) begin cc++; peak = 0; end
        if (amp[i] > peak) peak = amp[i];
        if (i == NP-1 || !mask[i+1]) if (peak < int'(ampMax)) anyOk = 1;
      end
    end
    acc = 0; reason = 0;
    if (!(pc > int'(pixMin) && pc < int'(pixMax))) reason = 0;
    else if (cc > int'(clusLimit)) reason = 1;
    else if (!anyOk) reason = 2;
    else acc = 1;
  endtask

  // Drives offsets 0..eff+1 (last two are after the window) and checks
  // the outcome in the strobe cycle. chain=1: opening hit driven in the
  // current cycle (right after the previous outcome sample).
  task automatic runEvent(input int wl, input bit chain, input string tag);
    int eff;
    bit acc; int reason; bit [15:0] mask; int pc; int cc;
    bit early;
    eff = (wl == 0) ? 1 : wl;
    winLen = 16'(wl);
    predict(wl, acc, reason, mask, pc, cc);
    early = 0;
    for (int o = 0; o <= eff + 1; o++) begin
      if (o > 0 || !chain) @(negedge clk);
      if (o > 0 && (acceptValid || rejectValid)) early = 1;
      hitValid = evV[o];
      hitPixel = 4'(evP[o]);
      hitAmp   = 12'(evA[o]);
    end
    @(negedge clk);
    hitValid = 1'b0;
    check(!early, "R4", {tag, " strobe before its cycle"}, early, 0);
    if (acc) begin
      check(acceptValid && !rejectValid, "R8", {tag, " accept strobe"},
            {acceptValid, rejectValid}, 2'b10);
      check(acceptMask == mask && int'(acceptPixCnt) == pc
            && int'(acceptClusCnt) == cc, "R8", {tag, " accept fields"},
            {acceptMask, acceptPixCnt, acceptClusCnt},
            {mask, 5'(pc), 5'(cc)});
    end else begin
      check(rejectValid && !acceptValid, "R9", {tag, " reject strobe"},
            {acceptValid, rejectValid}, 2'b01);
      check(int'(rejectReason) == reason,
            reason == 0 ? "R5" : (reason == 1 ? "R6" : "R7"),
            {tag, " reject reason"}, rejectReason, reason);
    end
  endtask

  task automatic setHit(input int o, input int p, input int a);
    evV[o] = 1; evP[o] = p; evA[o] = a;
  endtask

  task automatic idleGap();
    @(negedge clk);
    check(!acceptValid && !rejectValid, "R4", "strobe longer than one cycle",
          {acceptValid, rejectValid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C01C));
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!acceptValid && !rejectValid, "R10", "strobes in reset",
          {acceptValid, rejectValid}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!acceptValid && !rejectValid, "R10", "strobes after reset",
          {acceptValid, rejectValid}, 0);

    // R1: winLen 0 acts as 1; hit on next cycle is outside
    pixMin = 0; pixMax = 16; clusLimit = 8; ampMax = 12'hFFF;
    clearEvent(); setHit(0, 5, 100); setHit(1, 6, 100); setHit(2, 7, 100);
    runEvent(0, 0, "R1 winLen0");
    idleGap();

    // R2: repeated pixel keeps larger amplitude (rising then falling)
    ampMax = 800;
    clearEvent(); setHit(0, 3, 500); setHit(2, 3, 900); setHit(3, 3, 200);
    runEvent(4, 0, "R2 max kept");
    idleGap();

    // R3: hits after close ignored, back-to-back opens in strobe cycle
    ampMax = 12'hFFF;
    clearEvent(); setHit(0, 1, 10); setHit(1, 2, 20); setHit(2, 9, 30);
    setHit(3, 10, 40);
    runEvent(2, 0, "R3 late hits");
    clearEvent(); setHit(0, 12, 50);
    runEvent(1, 1, "R3 back-to-back");
    idleGap();

    // R5: pixel count on each bound
    pixMin = 2; pixMax = 5;
    clearEvent(); setHit(0, 0, 1); setHit(1, 4, 1);
    runEvent(3, 0, "R5 at min");
    clearEvent(); setHit(0, 0, 1); setHit(1, 4, 1); setHit(2, 8, 1);
    runEvent(3, 0, "R5 inside");
    clearEvent(); for (int o = 0; o < 5; o++) setHit(o, o * 3, 1);
    runEvent(5, 0, "R5 at max");

    // R6: cluster count at and past limit
    pixMin = 0; pixMax = 16; clusLimit = 2;
    clearEvent(); setHit(0, 0, 1); setHit(1, 1, 1); setHit(2, 6, 1);
    runEvent(3, 0, "R6 at limit");
    clearEvent(); setHit(0, 0, 1); setHit(1, 2, 1); setHit(2, 6, 1);
    runEvent(3, 0, "R6 over limit");

    // R7: amplitude equal to ceiling is vetoed; one low cluster accepts
    clusLimit = 8; ampMax = 300;
    clearEvent(); setHit(0, 4, 300); setHit(1, 5, 100);
    runEvent(2, 0, "R7 equal veto");
    clearEvent(); setHit(0, 4, 300); setHit(1, 9, 299);
    runEvent(2, 0, "R7 one low");

    // Random events
    for (int n = 0; n < 400; n++) begin
      int wl;
      if (n % 25 == 0) begin
        pixMin    = 5'($urandom_range(0, 3));
        pixMax    = 5'($urandom_range(3, 16));
        clusLimit = 5'($urandom_range(1, 5));
        ampMax    = 12'($urandom_range(200, 4095));
      end
      wl = $urandom_range(0, 8);
      clearEvent();
      for (int o = 0; o < 11; o++) begin
        evV[o] = (o == 0) || ($urandom_range(0, 99) < 60);
        evP[o] = $urandom_range(0, 15);
        evA[o] = $urandom_range(0, 4095);
      end
      runEvent(wl, 0, "random");
      if ($urandom_range(0, 1) == 1) idleGap();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule